// File: doc/BRIEF.md
# Stereo Halfword Packing Serial Audio Bridge

This block connects a 32-bit word stream on the memory side to a two-slot, 16-bit serial audio link in I2S-style framing. The transmitter and the receiver share one bit clock and one frame sync, and the block generates both. On the transmit side, each 32-bit word accepted from the source carries two samples. The lower halfword goes out in the even slot and the upper halfword follows in the odd slot. On the receive side, the sample taken in an even slot and the sample taken in the next odd slot are joined into one 32-bit word. The even-slot sample sits in the lower half, and the word is handed to the sink once the odd-slot sample is complete.

Each direction has one single-sample holding register between the word side and the shifter. The bridge writes a transmit sample only when the holding register has room, and it reads a receive sample only when one is waiting. Enabling the link starts a fixed priming sequence that keeps the two directions aligned on the same slots. A zero sample is already in the transmit holding register when the first slot starts. One more zero sample is written before streaming begins, and the first word the receiver completes is read and dropped. If a slot starts while the transmit holding register is empty, the slot carries zeros and a sticky underrun flag is raised.

Top module: `i2s_halfword_bridge`

## Requirements
- R1: While rst_n is low and after it is released with en low, bclk, fsync, sdout, src_ready, snk_valid and underrun are all 0.
- R2: With en high, bclk toggles every BCLK_HALF_DIV clock cycles, so each rising edge follows the previous one by 2*BCLK_HALF_DIV cycles. With en low, bclk stays 0.
- R3: A slot lasts 16 bit periods and a frame has two slots. fsync is 0 during slot 0 and 1 during slot 1, and it switches on the same rising bclk edge that presents the slot's first bit (no bit delay). The first rising edge after enable starts slot 0.
- R4: sdout changes only together with a rising bclk edge and carries each 16-bit sample most significant bit first.
- R5: After enable the transmitted slots are 0, then 0, then the lower halfword (bits 15:0) of the first accepted word, then its upper halfword (bits 31:16), then the same two halves of each following word in turn.
- R6: A source word is taken only in a cycle where src_valid and src_ready are both 1. src_ready is combinational and asserts at most once per two slots, so each accepted word supplies exactly two slots.
- R7: sdin is sampled on every rising bclk edge and the sample taken is the bit whose period ends at that edge. Sixteen such bits, most significant first, form one received sample.
- R8: The first received sample after enable holds no slot data and is dropped. After that, the slot 0 sample becomes snk_data[15:0] and the slot 1 sample becomes snk_data[31:16]. snk_valid is a one-cycle pulse per word.
- R9: If a slot starts while the transmit holding register is empty, that slot transmits all zeros and underrun goes to 1. underrun then stays 1 until rst_n is asserted, even while en is low.
- R10: Dropping en returns bclk, fsync, sdout, src_ready and snk_valid to 0 after one clock edge. A later enable replays the full priming sequence of R5 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Link enable; low holds the link idle and primed |
| src_data | input | 32 | Transmit word; two samples, lower half goes first |
| src_valid | input | 1 | src_data holds a word to send |
| src_ready | output | 1 | Word on src_data is taken at this clock edge |
| snk_data | output | 32 | Received word; slot 0 in low half, slot 1 in high half |
| snk_valid | output | 1 | One-cycle pulse, snk_data holds a new word |
| bclk | output | 1 | Serial bit clock |
| fsync | output | 1 | Frame sync, 0 in slot 0 and 1 in slot 1 |
| sdout | output | 1 | Serial transmit data |
| sdin | input | 1 | Serial receive data |
| underrun | output | 1 | Sticky transmit underrun flag |

## Verification
bclk, fsync and sdout all change on the clock edge where bclk rises. The bench therefore samples them at the following falling edge and counts 2*BCLK_HALF_DIV cycles between rising edges. A received word completes on the rising bclk edge that starts the next slot. snk_valid rises one clock later, and src_ready rises in the cycle right after a slot start empties the transmit holding register. With sdin looped to sdout, the sink stream is expected to be one zero word followed by the accepted words in order. The bench checks every slot and every sink word against values it generates from the run number and word index, so none of the checks depend on when a particular cycle happens to fall.

// File: rtl/i2s_hw_pkg.sv
package i2s_hw_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned WORD_W   = 2 * SAMPLE_W;

  typedef logic [SAMPLE_W-1:0] sample_t;
  typedef logic [WORD_W-1:0]   word_t;

  typedef enum logic [1:0] {TX_PRIME, TX_LOW, TX_HIGH} tx_state_t;
  typedef enum logic [1:0] {RX_DROP, RX_LOW, RX_HIGH} rx_state_t;

  // even-slot sample of a memory word
  function automatic sample_t lower_half(word_t w);
    return w[SAMPLE_W-1:0];
  endfunction

  // odd-slot sample of a memory word
  function automatic sample_t upper_half(word_t w);
    return w[WORD_W-1:SAMPLE_W];
  endfunction

  function automatic word_t join_halves(sample_t lo, sample_t hi);
    return {hi, lo};
  endfunction

  // value shifted out in a new slot: held sample or silence
  function automatic sample_t slot_load(logic have, sample_t held);
    return have ? held : '0;
  endfunction
endpackage

// File: rtl/i2s_bit_clock.sv
module i2s_bit_clock #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == CW'(HALF_DIV - 1));
  assign tick = run && wrap && !bclk;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2s_slot_engine.sv
module i2s_slot_engine
  import i2s_hw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    tick,
  input  logic    sdin,
  output logic    sdout,
  output logic    fsync,
  input  logic    tx_wr,
  input  sample_t tx_wdata,
  output logic    tx_space,
  input  logic    rx_rd,
  output sample_t rx_word,
  output logic    rx_avail,
  output logic    slot_start,
  output logic    underrun
);
  localparam int unsigned BW = $clog2(SAMPLE_W);

  logic [BW-1:0] bit_cnt;
  logic          next_slot;
  logic          last_bit;
  sample_t       tx_sh;
  sample_t       hold;
  logic          hold_full;
  sample_t       rx_sh;

  assign last_bit   = (bit_cnt == BW'(SAMPLE_W - 1));
  assign slot_start = tick && (bit_cnt == '0);
  assign sdout      = tx_sh[SAMPLE_W-1];
  assign tx_space   = !hold_full;

  // bit and slot position
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      bit_cnt   <= '0;
      next_slot <= 1'b0;
      fsync     <= 1'b0;
    end else if (tick) begin
      bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
      if (last_bit) next_slot <= ~next_slot;
      if (slot_start) fsync <= next_slot;
    end
  end

  // transmit holding register (preloaded with silence while idle) and shifter
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      hold      <= '0;
      hold_full <= 1'b1;
      tx_sh     <= '0;
    end else begin
      if (tx_wr) begin
        hold      <= tx_wdata;
        hold_full <= 1'b1;
      end else if (slot_start) begin
        hold_full <= 1'b0;
      end
      if (slot_start)  tx_sh <= slot_load(hold_full, hold);
      else if (tick)   tx_sh <= tx_sh << 1;
    end
  end

  // receive shifter and holding register
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      rx_sh    <= '0;
      rx_word  <= '0;
      rx_avail <= 1'b0;
    end else begin
      if (slot_start) begin
        rx_word  <= {rx_sh[SAMPLE_W-2:0], sdin};
        rx_sh    <= '0;
        rx_avail <= 1'b1;
      end else begin
        if (tick)  rx_sh    <= {rx_sh[SAMPLE_W-2:0], sdin};
        if (rx_rd) rx_avail <= 1'b0;
      end
    end
  end

  // sticky: only a full reset clears it
  always_ff @(posedge clk) begin
    if (!rst_n)                               underrun <= 1'b0;
    else if (run && slot_start && !hold_full) underrun <= 1'b1;
  end
endmodule

// File: rtl/i2s_tx_packer.sv
module i2s_tx_packer
  import i2s_hw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  word_t   src_data,
  input  logic    src_valid,
  output logic    src_ready,
  input  logic    tx_space,
  output logic    tx_wr,
  output sample_t tx_wdata
);
  tx_state_t state;
  sample_t   upper_q;

  always_comb begin
    tx_wr     = 1'b0;
    tx_wdata  = '0;
    src_ready = 1'b0;
    if (run) begin
      case (state)
        TX_PRIME: tx_wr = tx_space;
        TX_LOW: begin
          src_ready = tx_space && src_valid;
          tx_wr     = src_ready;
          tx_wdata  = lower_half(src_data);
        end
        TX_HIGH: begin
          tx_wr    = tx_space;
          tx_wdata = upper_q;
        end
        default: tx_wr = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      state   <= TX_PRIME;
      upper_q <= '0;
    end else begin
      case (state)
        TX_PRIME: if (tx_space) state <= TX_LOW;
        TX_LOW: if (src_ready) begin
          upper_q <= upper_half(src_data);
          state   <= TX_HIGH;
        end
        TX_HIGH: if (tx_space) state <= TX_LOW;
        default: state <= TX_PRIME;
      endcase
    end
  end
endmodule

// File: rtl/i2s_rx_unpacker.sv
module i2s_rx_unpacker
  import i2s_hw_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    rx_avail,
  input  sample_t rx_word,
  output logic    rx_rd,
  output word_t   snk_data,
  output logic    snk_valid
);
  rx_state_t state;
  sample_t   lower_q;

  assign rx_rd = run && rx_avail;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      state     <= RX_DROP;
      lower_q   <= '0;
      snk_valid <= 1'b0;
      if (!rst_n) snk_data <= '0;
    end else begin
      snk_valid <= 1'b0;
      if (rx_avail) begin
        case (state)
          RX_DROP: state <= RX_LOW;
          RX_LOW: begin
            lower_q <= rx_word;
            state   <= RX_HIGH;
          end
          RX_HIGH: begin
            snk_data  <= join_halves(lower_q, rx_word);
            snk_valid <= 1'b1;
            state     <= RX_LOW;
          end
          default: state <= RX_DROP;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2s_halfword_bridge.sv
module i2s_halfword_bridge
  import i2s_hw_pkg::*;
#(
  parameter int unsigned BCLK_HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] src_data,
  input  logic              src_valid,
  output logic              src_ready,
  output logic [WORD_W-1:0] snk_data,
  output logic              snk_valid,
  output logic              bclk,
  output logic              fsync,
  output logic              sdout,
  input  logic              sdin,
  output logic              underrun
);
  // internal events, named for the checker
  logic    tick;
  logic    slot_start;
  logic    tx_wr;
  sample_t tx_wdata;
  logic    tx_space;
  logic    rx_rd;
  sample_t rx_word;
  logic    rx_avail;

  i2s_bit_clock #(.HALF_DIV(BCLK_HALF_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(en), .bclk(bclk), .tick(tick)
  );

  i2s_slot_engine u_eng (
    .clk(clk), .rst_n(rst_n), .run(en), .tick(tick), .sdin(sdin),
    .sdout(sdout), .fsync(fsync),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_space(tx_space),
    .rx_rd(rx_rd), .rx_word(rx_word), .rx_avail(rx_avail),
    .slot_start(slot_start), .underrun(underrun)
  );

  i2s_tx_packer u_txp (
    .clk(clk), .rst_n(rst_n), .run(en),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .tx_space(tx_space), .tx_wr(tx_wr), .tx_wdata(tx_wdata)
  );

  i2s_rx_unpacker u_rxu (
    .clk(clk), .rst_n(rst_n), .run(en),
    .rx_avail(rx_avail), .rx_word(rx_word), .rx_rd(rx_rd),
    .snk_data(snk_data), .snk_valid(snk_valid)
  );
endmodule

// File: rtl/i2s_halfword_bridge_chk.sv
module i2s_halfword_bridge_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic bclk,
  input logic fsync,
  input logic sdout,
  input logic src_valid,
  input logic src_ready,
  input logic snk_valid,
  input logic underrun,
  input logic tx_wr,
  input logic tx_space,
  input logic rx_rd,
  input logic rx_avail
);
  // R2
  bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bclk);

  // R4
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (sdout != $past(sdout))) |-> (bclk && !$past(bclk)));

  // R3
  fsync_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (fsync != $past(fsync))) |-> (bclk && !$past(bclk)));

  // R6
  src_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> src_valid);

  // R6
  hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |-> tx_space);

  // R8
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rd |-> rx_avail);

  // R8
  snk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |=> !snk_valid);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
endmodule

bind i2s_halfword_bridge i2s_halfword_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bclk(bclk), .fsync(fsync),
  .sdout(sdout), .src_valid(src_valid), .src_ready(src_ready),
  .snk_valid(snk_valid), .underrun(underrun), .tx_wr(tx_wr),
  .tx_space(tx_space), .rx_rd(rx_rd), .rx_avail(rx_avail)
);

// File: tb/i2s_halfword_bridge_bench.sv
module i2s_halfword_bridge_bench;
  localparam int HALF = 2;
  localparam int PER  = 2 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [31:0] snk_data;
  logic        snk_valid;
  logic        bclk, fsync, sdout, sdin, underrun;

  always #2 clk = ~clk;
  assign sdin = sdout; // loopback

  i2s_halfword_bridge #(.BCLK_HALF_DIV(HALF)) u_i2s_halfword_bridge (
    .clk(clk), .rst_n(rst_n), .en(en),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .snk_data(snk_data), .snk_valid(snk_valid),
    .bclk(bclk), .fsync(fsync), .sdout(sdout), .sdin(sdin),
    .underrun(underrun)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int run_id = 0, nwords = 0, idx = 0, accepted = 0;
  int rises = 0, sidx = 0, rx_idx = 0, cyc = 0, last_rise = 0;
  logic        prev_bclk = 1'b0, prev_sdout = 1'b0;
  logic [15:0] acc = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wgen(int r, int i);
    logic [15:0] lo, hi;
    lo = 16'(i * 16'h9D27) ^ 16'h8421 ^ 16'(r);
    hi = 16'(r * 16'h0F1D + i * 16'h3A57 + 16'h1111);
    return {hi, lo};
  endfunction

  // R5: two silent priming slots, then lower then upper half of each word
  function automatic logic [15:0] exp_slot(int r, int n, int s);
    int k;
    logic [31:0] w;
    if (s < 2) return 16'h0;
    k = s - 2;
    if (k / 2 >= n) return 16'h0;
    w = wgen(r, k / 2);
    return (k % 2 == 1) ? w[31:16] : w[15:0];
  endfunction

  // R8: first sink word carries the two priming slots, then the words in order
  function automatic logic [31:0] exp_rx(int r, int n, int q);
    if (q == 0 || q - 1 >= n) return 32'h0;
    return wgen(r, q - 1);
  endfunction

  // serial and sink monitor, sampling away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!en) begin
      rises = 0; sidx = 0; rx_idx = 0; acc = '0;
    end else begin
      if (bclk && !prev_bclk) begin
        if (rises > 0) chk(cyc - last_rise == PER, "R2 bclk period", cyc - last_rise, PER);
        last_rise = cyc;
        chk(fsync == ((rises / 16) % 2 == 1), "R3 fsync slot", fsync, (rises / 16) % 2);
        acc = {acc[14:0], sdout};
        if (rises % 16 == 15) begin
          if (sidx < 2 * nwords + 8)
            chk(acc == exp_slot(run_id, nwords, sidx), "R5 slot value", acc,
                exp_slot(run_id, nwords, sidx));
          sidx++;
        end
        rises++;
      end else if (rises > 0) begin
        chk(sdout == prev_sdout, "R4 sdout stable between rising edges", sdout, prev_sdout);
      end
      if (snk_valid) begin
        if (rx_idx < nwords + 3)
          chk(snk_data == exp_rx(run_id, nwords, rx_idx), "R7 R8 sink word", snk_data,
              exp_rx(run_id, nwords, rx_idx));
        rx_idx++;
      end
    end
    prev_bclk  = bclk;
    prev_sdout = sdout;
  end

  // source driver: advance after each accepting edge
  initial begin
    forever begin
      @(negedge clk);
      if (src_valid && src_ready) begin
        @(posedge clk);
        #1;
        idx++;
        accepted++;
        if (idx < nwords) src_data = wgen(run_id, idx);
        else src_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", sidx, 2 * nwords + 8);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic start_run(input int r, input int n);
    @(negedge clk);
    run_id = r; nwords = n; idx = 0; accepted = 0;
    src_data = wgen(r, 0);
    src_valid = 1'b1;
    en = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    chk({bclk, fsync, sdout, src_ready, snk_valid, underrun} == 6'b0, "R1 reset",
        {bclk, fsync, sdout, src_ready, snk_valid, underrun}, 0);
    rst_n = 1'b1;
    // R2: idle with en low
    repeat (20) begin
      @(negedge clk);
      chk(bclk == 1'b0, "R2 idle bclk", bclk, 0);
    end
    chk({fsync, sdout, src_ready, underrun} == 4'b0, "R1 idle after release",
        {fsync, sdout, src_ready, underrun}, 0);

    // run 0: long stream, then source stops
    start_run(0, 24);
    while (idx < nwords) @(negedge clk);
    chk(underrun == 1'b0, "R9 no underrun while fed", underrun, 0);
    while (sidx < 2 * nwords + 8) @(negedge clk);
    chk(accepted == nwords, "R6 words accepted", accepted, nwords);
    chk(rx_idx >= nwords + 3, "R8 sink word count", rx_idx, nwords + 3);
    chk(underrun == 1'b1, "R9 underrun after source stops", underrun, 1);

    // R10: disable
    en = 1'b0;
    @(negedge clk);
    chk({bclk, fsync, sdout, src_ready, snk_valid} == 5'b0, "R10 idle after disable",
        {bclk, fsync, sdout, src_ready, snk_valid}, 0);
    repeat (10) @(negedge clk);
    chk(underrun == 1'b1, "R9 underrun sticky while disabled", underrun, 1);

    // R10: re-enable replays priming
    start_run(1, 6);
    while (sidx < 2 * nwords + 6) @(negedge clk);
    chk(accepted == nwords, "R6 R10 words accepted", accepted, nwords);
    chk(rx_idx >= nwords + 2, "R8 R10 sink word count", rx_idx, nwords + 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule